// File: doc/BRIEF.md
# Fetch-Stage Branch Direction and Target Predictor

This block sits beside the instruction fetch stage. For each fetch address it returns three results in the same cycle: a taken/not-taken guess, a flag that says a target is known for that address, and the address to fetch next. The direction guess comes from a table of 2-bit saturating counters. The target comes from a small tagged cache of branch destinations. Both structures are direct-mapped and indexed by the low-order word-address bits of the PC. When the next address is the cached target, fetch can redirect with no lost cycle. Otherwise the next address is the sequential one.

When a branch resolves later in the pipeline, its address, its real outcome and its real destination arrive on the training port. The counter for that slot moves one step toward the real outcome and stops at either end. Because of this hysteresis, a strongly biased branch needs two wrong guesses in a row before its prediction flips. A loop-closing branch therefore costs only one mispredict each time the loop exits. Taken branches also fill the target cache. Choosing the redirect and flushing the pipeline are left to the surrounding logic.

Top module: `bp_predictor`

## Requirements
- R1: After reset every counter holds 01 (weakly not taken) and every target entry is invalid. Any fetch address then gives pred_taken=0 and tgt_hit=0.
- R2: pred_taken equals bit 1 of the counter selected by fetch_pc[IDX_W+1:2]. The counter codes are 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken.
- R3: A training event with upd_taken=1 raises the selected counter by one. The counter stays at 11 once it gets there.
- R4: A training event with upd_taken=0 lowers the selected counter by one. The counter stays at 00 once it gets there.
- R5: A branch in a strong state keeps its prediction after one opposite outcome. The prediction flips only after a second opposite outcome in a row.
- R6: A training event with upd_taken=1 writes the selected target entry as valid, with tag upd_pc[PC_W-1:IDX_W+2] and target upd_target.
- R7: tgt_hit is 1 only when the selected entry is valid and its tag matches fetch_pc[PC_W-1:IDX_W+2]. An address that shares the index but has a different tag misses, while it still shares the same direction counter.
- R8: A training event with upd_taken=0 leaves the target cache unchanged.
- R9: pred_target is the cached target when pred_taken and tgt_hit are both 1. In every other case it is fetch_pc+4.
- R10: A training event changes only the slot selected by upd_pc. Every other slot keeps its counter and its target entry.
- R11: In a trained nested loop whose inner branch is taken three times and then falls through, the inner branch is mispredicted exactly once per pass of the outer loop.
- R12: A lookup shows the table state from before any training event in the same cycle. Training takes effect on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | PC_W | Address being fetched |
| pred_taken | output | 1 | Direction guess for fetch_pc |
| tgt_hit | output | 1 | Valid target entry with a matching tag |
| pred_target | output | PC_W | Next fetch address |
| upd_valid | input | 1 | Training event strobe |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome |
| upd_target | input | PC_W | Resolved destination |

## Verification
A sweep over every slot applies outcome sequences generated by formula, mixing runs and alternations. A counter model in the bench predicts each lookup, so saturation at both ends and spill-over into other slots show up as mismatches. Targeted sequences separate a one-step change from the required two-step flip. They also separate a tag match from an index-only match and a taken write from a not-taken write. A nested-loop trace then confirms that a trained inner branch costs exactly one mispredict per exit.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_e;

    localparam logic [1:0] CTR_RESET = CTR_WEAK_NT;

    // one saturating step toward the observed outcome
    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
        logic [1:0] nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_STRONG_T) nxt = cur + 2'd1;
        end else begin
            if (cur != CTR_STRONG_NT) nxt = cur - 2'd1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/bp_pc_split.sv
module bp_pc_split #(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 4,
    parameter int ALIGN_W = 2,
    localparam int TAG_W  = PC_W - IDX_W - ALIGN_W
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);
    always_comb begin
        idx = pc[ALIGN_W +: IDX_W];
        tag = pc[PC_W-1 -: TAG_W];
    end
endmodule

// File: rtl/bp_dir_table.sv
module bp_dir_table
    import bp_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    typedef struct packed {
        logic [DEPTH-1:0][1:0] ctr;
    } dir_state_t;

    dir_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctr[wr_idx] = ctr_step(st_q.ctr[wr_idx], wr_taken);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctr <= {DEPTH{CTR_RESET}};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_taken = st_q.ctr[rd_idx][1];
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_chk
        p_step_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(g) && wr_taken && st_q.ctr[g] != 2'b11)
            |=> st_q.ctr[g] == $past(st_q.ctr[g]) + 2'd1);
        p_hold_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(g) && wr_taken && st_q.ctr[g] == 2'b11)
            |=> st_q.ctr[g] == 2'b11);
        p_step_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(g) && !wr_taken && st_q.ctr[g] != 2'b00)
            |=> st_q.ctr[g] == $past(st_q.ctr[g]) - 2'd1);
        p_hold_bot_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(g) && !wr_taken && st_q.ctr[g] == 2'b00)
            |=> st_q.ctr[g] == 2'b00);
        p_idle_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_idx == IDX_W'(g)) |=> $stable(st_q.ctr[g]));
    end
endmodule

// File: rtl/bp_target_cache.sv
module bp_target_cache #(
    parameter int DEPTH = 16,
    parameter int TAG_W = 26,
    parameter int PC_W  = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output logic [PC_W-1:0]  rd_target,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_target
);
    typedef struct packed {
        logic [DEPTH-1:0]            vld;
        logic [DEPTH-1:0][TAG_W-1:0] tag;
        logic [DEPTH-1:0][PC_W-1:0]  tgt;
    } btc_state_t;

    btc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.vld[wr_idx] = 1'b1;
            st_d.tag[wr_idx] = wr_tag;
            st_d.tgt[wr_idx] = wr_target;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_hit    = st_q.vld[rd_idx] && (st_q.tag[rd_idx] == rd_tag);
        rd_target = st_q.tgt[rd_idx];
    end

    p_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> st_q.vld[$past(wr_idx)] && st_q.tag[$past(wr_idx)] == $past(wr_tag)
                  && st_q.tgt[$past(wr_idx)] == $past(wr_target));
    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q));
endmodule

// File: rtl/bp_predictor.sv
module bp_predictor #(
    parameter int PC_W    = 32,
    parameter int DEPTH   = 16,
    parameter int ALIGN_W = 2,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int TAG_W  = PC_W - IDX_W - ALIGN_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_taken,
    output logic            tgt_hit,
    output logic [PC_W-1:0] pred_target,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target
);
    localparam logic [PC_W-1:0] STEP = PC_W'(1) << ALIGN_W;

    logic [IDX_W-1:0] f_idx, u_idx;
    logic [TAG_W-1:0] f_tag, u_tag;
    logic [PC_W-1:0]  cache_tgt;
    logic             cache_wr;

    bp_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) u_split_fetch (
        .pc(fetch_pc), .idx(f_idx), .tag(f_tag)
    );
    bp_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) u_split_upd (
        .pc(upd_pc), .idx(u_idx), .tag(u_tag)
    );

    bp_dir_table #(.DEPTH(DEPTH)) u_dir (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(f_idx), .rd_taken(pred_taken),
        .wr_en(upd_valid), .wr_idx(u_idx), .wr_taken(upd_taken)
    );

    always_comb cache_wr = upd_valid && upd_taken;

    bp_target_cache #(.DEPTH(DEPTH), .TAG_W(TAG_W), .PC_W(PC_W)) u_btc (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(f_idx), .rd_tag(f_tag), .rd_hit(tgt_hit), .rd_target(cache_tgt),
        .wr_en(cache_wr), .wr_idx(u_idx), .wr_tag(u_tag), .wr_target(upd_target)
    );

    always_comb begin
        pred_target = (pred_taken && tgt_hit) ? cache_tgt : fetch_pc + STEP;
    end

    p_cold_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !pred_taken && !tgt_hit);
    p_stable_lookup_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_valid && $stable(fetch_pc)) |=> $stable(pred_target) || $changed(fetch_pc));
endmodule

// File: tb/bp_predictor_bench.sv
module bp_predictor_bench;
    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] fetch_pc = '0;
    logic            pred_taken, tgt_hit;
    logic [PC_W-1:0] pred_target;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;
    logic [PC_W-1:0] upd_target = '0;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    logic [1:0]  cnt_m [16];
    logic        vld_m [16];
    logic [25:0] tag_m [16];
    logic [31:0] tgt_m [16];

    bp_predictor u_bp_predictor (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .pred_taken(pred_taken), .tgt_hit(tgt_hit), .pred_target(pred_target),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target)
    );

    always #10ns clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 16; i++) begin
            cnt_m[i] = 2'b01; vld_m[i] = 1'b0; tag_m[i] = '0; tgt_m[i] = '0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    task automatic train(input logic [31:0] pc, input bit taken, input logic [31:0] tgt);
        int idx;
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_taken = taken; upd_target = tgt;
        @(negedge clk);
        upd_valid = 1'b0;
        idx = int'(pc[5:2]);
        if (taken) begin
            if (cnt_m[idx] != 2'b11) cnt_m[idx] = cnt_m[idx] + 2'd1;
            vld_m[idx] = 1'b1; tag_m[idx] = pc[31:6]; tgt_m[idx] = tgt;
        end else if (cnt_m[idx] != 2'b00) begin
            cnt_m[idx] = cnt_m[idx] - 2'd1;
        end
    endtask

    // lookup, compare against the model
    task automatic look(input logic [31:0] pc, input string req);
        int idx;
        bit e_tk, e_hit;
        logic [31:0] e_tgt;
        idx = int'(pc[5:2]);
        e_tk = cnt_m[idx][1];
        e_hit = vld_m[idx] && (tag_m[idx] == pc[31:6]);
        e_tgt = (e_tk && e_hit) ? tgt_m[idx] : pc + 32'd4;
        fetch_pc = pc;
        #2ns;
        chk(pred_taken === e_tk, {req, " R2 direction"}, 32'(pred_taken), 32'(e_tk));
        chk(tgt_hit === e_hit, {req, " R7 hit"}, 32'(tgt_hit), 32'(e_hit));
        chk(pred_target === e_tgt, {req, " R9 target"}, pred_target, e_tgt);
    endtask

    initial begin
        #(20ns * 150000);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        model_clear();
        do_reset();

        // R1: cold state over every slot
        for (int i = 0; i < 16; i++) begin
            fetch_pc = 32'h0000_1000 + 32'(i * 4);
            #2ns;
            chk(pred_taken === 1'b0, "R1 cold direction", 32'(pred_taken), 0);
            chk(tgt_hit === 1'b0, "R1 cold hit", 32'(tgt_hit), 0);
            chk(pred_target === fetch_pc + 32'd4, "R1 R9 cold target", pred_target, fetch_pc + 32'd4);
        end

        // R3 R4 R6 R10: sweep every slot with formula-driven outcomes
        for (int i = 0; i < 16; i++) begin
            for (int k = 0; k < 8; k++) begin
                train(32'h0000_1000 + 32'(i * 4), ((i * 5 + k * 3) % 7) < 4,
                      32'h0000_8000 + 32'(i * 16 + k * 4));
                look(32'h0000_1000 + 32'(i * 4), "R3 R4 R6 sweep");
            end
        end
        for (int i = 0; i < 16; i++) look(32'h0000_1000 + 32'(i * 4), "R10 isolation");

        // R12: lookup in the same cycle as training shows old state
        do_reset();
        @(negedge clk);
        fetch_pc = 32'h0000_2008;
        upd_valid = 1'b1; upd_pc = 32'h0000_2008; upd_taken = 1'b1; upd_target = 32'h0000_9000;
        #2ns;
        chk(tgt_hit === 1'b0, "R12 same-cycle hit", 32'(tgt_hit), 0);
        @(negedge clk);
        upd_valid = 1'b0;
        cnt_m[2] = 2'b10; vld_m[2] = 1'b1; tag_m[2] = 26'h80; tgt_m[2] = 32'h0000_9000;
        look(32'h0000_2008, "R12 next cycle");
        chk(pred_target === 32'h0000_9000, "R12 redirect", pred_target, 32'h0000_9000);

        // R5: hysteresis from strong taken
        do_reset();
        train(32'h0000_200c, 1, 32'h0000_a000);
        train(32'h0000_200c, 1, 32'h0000_a000);
        look(32'h0000_200c, "R5 strong");
        train(32'h0000_200c, 0, 32'h0);
        #1ns fetch_pc = 32'h0000_200c; #2ns;
        chk(pred_taken === 1'b1, "R5 one miss keeps taken", 32'(pred_taken), 1);
        train(32'h0000_200c, 0, 32'h0);
        #1ns fetch_pc = 32'h0000_200c; #2ns;
        chk(pred_taken === 1'b0, "R5 second miss flips", 32'(pred_taken), 0);

        // R4: saturate low, one taken stays not taken
        for (int k = 0; k < 4; k++) train(32'h0000_200c, 0, 32'h0);
        train(32'h0000_200c, 1, 32'h0000_a000);
        #1ns fetch_pc = 32'h0000_200c; #2ns;
        chk(pred_taken === 1'b0, "R4 floor saturation", 32'(pred_taken), 0);
        // R3: saturate high, one not taken stays taken
        for (int k = 0; k < 5; k++) train(32'h0000_200c, 1, 32'h0000_a000);
        train(32'h0000_200c, 0, 32'h0);
        #1ns fetch_pc = 32'h0000_200c; #2ns;
        chk(pred_taken === 1'b1, "R3 ceiling saturation", 32'(pred_taken), 1);
        train(32'h0000_200c, 1, 32'h0000_a000);

        // R7: same index, different tag
        look(32'h0000_204c, "R7 alias");
        chk(tgt_hit === 1'b0 && pred_taken === 1'b1, "R7 alias miss shared ctr",
            {30'd0, tgt_hit, pred_taken}, 32'h1);

        // R8: not-taken training keeps cached target
        train(32'h0000_200c, 0, 32'h0000_dead);
        look(32'h0000_200c, "R8 after not-taken");
        chk(pred_target === 32'h0000_a000, "R8 target kept", pred_target, 32'h0000_a000);

        // R11: nested loop, inner taken 3 times then exits
        do_reset();
        for (int o = 0; o < 6; o++) begin
            int mis;
            mis = 0;
            for (int k = 0; k < 4; k++) begin
                bit act;
                act = (k < 3);
                look(32'h0000_0100, "R11 inner");
                if (pred_taken !== act) mis++;
                train(32'h0000_0100, act, 32'h0000_00f0);
            end
            look(32'h0000_0120, "R11 outer");
            train(32'h0000_0120, 1, 32'h0000_00e0);
            if (o >= 2) chk(mis == 1, "R11 one miss per exit", 32'(mis), 1);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule